// File: doc/BRIEF.md
# Edge-Event GPIO Controller

A 32-pin general-purpose I/O block attached to a small word-wide register bus. Software chooses, pin by pin, whether a pin is driven or observed. It holds an open-drain setting for each pin and reads or writes pin levels through one shared data word. Input pins are brought into the clock domain through a synchroniser chain. Every change an input pin makes can set a sticky per-pin event flag. For each pin, software chooses whether the flag is set on any edge or only on a high-to-low edge.

Software enables event flags through a mask. The block raises a single interrupt line while any enabled flag is set. A handler reads the event word and writes ones back to acknowledge the flags it has serviced. Pins are numbered from the most significant end: pin n lives in register bit 31−n, and on the pin vectors as well.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Word registers sit at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 event mask, 0x14 edge select. A word read returns the register's value on `bus_rdata` in the cycle after the request.
- R2: A read of any other offset, including an offset that is not word-aligned, returns zero. `bus_rdata` is zero in every cycle that does not follow an accepted read.
- R3: A direction bit of 1 makes the pin an output. `pin_oe` equals the direction register, and `pin_out` equals the data bit for output pins and 0 for input pins. A data write reaches `pin_out` one cycle after the write cycle.
- R4: For an input pin, the data bit takes the external level three clock edges after `pin_in` changes. A data write does not alter it. For an output pin, changes on `pin_in` alter neither the data bit nor the event bit.
- R5: On an input pin whose edge-select bit is 0, any level change sets its event bit. With edge select 1, only a 1-to-0 change sets it. The event bit is set three edges after the `pin_in` change.
- R6: A write to the event register clears each bit written as 1 and leaves bits written as 0 unchanged. An edge that sets a bit in the same cycle as a clearing write for that bit leaves the bit set.
- R7: `irq` is high exactly when the event register AND the mask register is nonzero. It follows those registers without extra delay.
- R8: Only accesses with `bus_size` = 2'b10 (four bytes) take effect. Other sizes leave every register unchanged on a write and return zero on a read.
- R9: Synchronous reset clears all six registers, the synchroniser and `bus_rdata`. After reset, every pin is an input, `irq` is low and `pin_out` is zero.
- R10: The open-drain register is stored and readable, and it is presented unchanged on `pin_od`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | 32 | External pin levels, bit 31−n is pin n |
| pin_out | output | 32 | Driven level for output pins |
| pin_oe | output | 32 | Output enable per pin |
| pin_od | output | 32 | Open-drain selection per pin |
| irq | output | 1 | Masked OR of event flags |

## Verification
Several properties are checked on every cycle. No event bit is newly set on a pin that was an output. No event bit is cleared unless a one was written to it. Output-pin data bits hold their value between data writes. Undersized accesses change no register, and unmapped or undersized reads return zero. Other behaviour can only be shown by the bench's scenarios against its reference model. That covers the edge-kind selection, the three-edge latency from pin to flag, the edge-over-clear priority and the masked interrupt level.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_OD    = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_EVENT = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_EDGE  = 12'h014;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_OD,
        SEL_DATA,
        SEL_EVENT,
        SEL_MASK,
        SEL_EDGE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic dir;
        logic od;
        logic data;
        logic event_clr;
        logic mask;
        logic edge_sel;
    } wr_strobe_t;

    function automatic reg_sel_e offset_to_sel(input logic [ADDR_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_DIR:   s = SEL_DIR;
            OFS_OD:    s = SEL_OD;
            OFS_DATA:  s = SEL_DATA;
            OFS_EVENT: s = SEL_EVENT;
            OFS_MASK:  s = SEL_MASK;
            OFS_EDGE:  s = SEL_EDGE;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Event condition for one pin: falling-only when fall_only, else any change.
    function automatic logic edge_hit(input logic prev, input logic now, input logic fall_only);
        return fall_only ? (prev & ~now) : (prev ^ now);
    endfunction

endpackage

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
    import gpio_edge_pkg::*;
(
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [1:0]          bus_size,
    input  logic [ADDR_W-1:0]   bus_addr,
    output wr_strobe_t          wr,
    output logic                rd_en,
    output reg_sel_e            sel
);

    logic word_ok;
    logic wr_ok;

    always_comb begin
        word_ok = (bus_size == SIZE_WORD);
        sel     = offset_to_sel(bus_addr);
        wr_ok   = bus_valid && bus_write && word_ok;
        rd_en   = bus_valid && !bus_write && word_ok && (sel != SEL_NONE);
        wr      = '0;
        if (wr_ok) begin
            case (sel)
                SEL_DIR:   wr.dir       = 1'b1;
                SEL_OD:    wr.od        = 1'b1;
                SEL_DATA:  wr.data      = 1'b1;
                SEL_EVENT: wr.event_clr = 1'b1;
                SEL_MASK:  wr.mask      = 1'b1;
                SEL_EDGE:  wr.edge_sel  = 1'b1;
                default:   wr           = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_sampler.sv
module gpio_edge_sampler #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] level,
    output logic [W-1:0] level_prev
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_prev <= '0;
        else     level_prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/gpio_edge_event.sv
module gpio_edge_event
    import gpio_edge_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] level_prev,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] fall_only,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] flags
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic hit;
        logic clr;
        always_comb begin
            hit = !dir[i] && edge_hit(level_prev[i], level[i], fall_only[i]);
            clr = clr_en && clr_bits[i];
        end
        // A new edge takes priority over an acknowledge in the same cycle.
        always_ff @(posedge clk) begin
            if (rst)      flags[i] <= 1'b0;
            else if (hit) flags[i] <= 1'b1;
            else if (clr) flags[i] <= 1'b0;
        end
    end

    // R5: a flag can only be raised on a pin that was an input
    a_r5_no_event_on_output: assert property (@(posedge clk) disable iff (rst)
        ((flags & ~$past(flags) & $past(dir)) == '0));

    // R6: a flag only drops where a one was written to the event register
    a_r6_clear_only_written: assert property (@(posedge clk) disable iff (rst)
        (($past(flags) & ~flags & ~($past(clr_en) ? $past(clr_bits) : '0)) == '0));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  pin_in,
    output logic [REG_W-1:0]  pin_out,
    output logic [REG_W-1:0]  pin_oe,
    output logic [REG_W-1:0]  pin_od,
    output logic              irq
);

    wr_strobe_t       wr;
    logic             rd_en;
    reg_sel_e         sel;

    logic [REG_W-1:0] dir_q;
    logic [REG_W-1:0] od_q;
    logic [REG_W-1:0] data_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] edge_q;
    logic [REG_W-1:0] flags;
    logic [REG_W-1:0] level;
    logic [REG_W-1:0] level_prev;
    logic [REG_W-1:0] data_d;
    logic [REG_W-1:0] rd_mux;

    gpio_edge_decode u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .wr        (wr),
        .rd_en     (rd_en),
        .sel       (sel)
    );

    gpio_edge_sampler #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (pin_in),
        .level      (level),
        .level_prev (level_prev)
    );

    gpio_edge_event #(.W(REG_W)) u_event (
        .clk        (clk),
        .rst        (rst),
        .level      (level),
        .level_prev (level_prev),
        .dir        (dir_q),
        .fall_only  (edge_q),
        .clr_en     (wr.event_clr),
        .clr_bits   (bus_wdata),
        .flags      (flags)
    );

    // Output bits keep or take written data; input bits follow the sampled level.
    always_comb begin
        data_d = (dir_q & (wr.data ? bus_wdata : data_q)) | (~dir_q & level);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            od_q   <= '0;
            data_q <= '0;
            mask_q <= '0;
            edge_q <= '0;
        end else begin
            if (wr.dir)      dir_q  <= bus_wdata;
            if (wr.od)       od_q   <= bus_wdata;
            if (wr.mask)     mask_q <= bus_wdata;
            if (wr.edge_sel) edge_q <= bus_wdata;
            data_q <= data_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR:   rd_mux = dir_q;
            SEL_OD:    rd_mux = od_q;
            SEL_DATA:  rd_mux = data_q;
            SEL_EVENT: rd_mux = flags;
            SEL_MASK:  rd_mux = mask_q;
            SEL_EDGE:  rd_mux = edge_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
        else            bus_rdata <= '0;
    end

    assign pin_oe  = dir_q;
    assign pin_out = data_q & dir_q;
    assign pin_od  = od_q;
    assign irq     = |(flags & mask_q);

    // R2: unmapped offsets read as zero
    a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && (offset_to_sel(bus_addr) == SEL_NONE)) |=> (bus_rdata == '0));

    // R8: undersized writes change no configuration
    a_r8_size_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && (bus_size != SIZE_WORD))
            |=> ($stable(dir_q) && $stable(mask_q) && $stable(edge_q) && $stable(od_q)));

    // R8: undersized reads return zero
    a_r8_size_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && (bus_size != SIZE_WORD)) |=> (bus_rdata == '0));

    // R4: output-pin data bits hold between data writes
    a_r4_output_data_holds: assert property (@(posedge clk) disable iff (rst)
        !wr.data |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));

    // R9: reset leaves every pin an input and the interrupt low
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && !irq && bus_rdata == '0));

endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] pin_od;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
        .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_dir, m_od, m_data, m_ev, m_mask, m_edge, m_rdata;
    logic [31:0] hist [$];

    always @(posedge clk) begin
        logic [31:0] lvl, old, hit;
        logic [31:0] nxt_rd;
        bit word;
        if (rst) begin
            m_dir = 0; m_od = 0; m_data = 0; m_ev = 0;
            m_mask = 0; m_edge = 0; m_rdata = 0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            lvl = hist[1];
            old = hist[0];
            for (int b = 0; b < 32; b++) begin
                if (m_dir[b]) hit[b] = 1'b0;
                else if (m_edge[b]) hit[b] = old[b] && !lvl[b];
                else hit[b] = old[b] != lvl[b];
            end
            word = (bus_size == 2'b10);
            nxt_rd = 0;
            if (bus_valid && !bus_write && word) begin
                case (bus_addr)
                    12'h000: nxt_rd = m_dir;
                    12'h004: nxt_rd = m_od;
                    12'h008: nxt_rd = m_data;
                    12'h00C: nxt_rd = m_ev;
                    12'h010: nxt_rd = m_mask;
                    12'h014: nxt_rd = m_edge;
                    default: nxt_rd = 0;
                endcase
            end
            for (int b = 0; b < 32; b++) begin
                if (!m_dir[b]) m_data[b] = lvl[b];
                else if (bus_valid && bus_write && word && bus_addr == 12'h008) m_data[b] = bus_wdata[b];
            end
            if (bus_valid && bus_write && word && bus_addr == 12'h00C) m_ev = m_ev & ~bus_wdata;
            m_ev = m_ev | hit;
            if (bus_valid && bus_write && word) begin
                case (bus_addr)
                    12'h000: m_dir = bus_wdata;
                    12'h004: m_od = bus_wdata;
                    12'h010: m_mask = bus_wdata;
                    12'h014: m_edge = bus_wdata;
                    default: ;
                endcase
            end
            m_rdata = nxt_rd;
            hist.push_back(pin_in);
            void'(hist.pop_front());
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(bus_rdata === m_rdata, "R1 rdata vs model", bus_rdata, m_rdata);
            chk(pin_out === (m_data & m_dir), "R3 pin_out vs model", pin_out, m_data & m_dir);
            chk(pin_oe === m_dir, "R3 pin_oe vs model", pin_oe, m_dir);
            chk(pin_od === m_od, "R10 pin_od vs model", pin_od, m_od);
            chk(irq === (|(m_ev & m_mask)), "R7 irq vs model", {31'b0, irq}, {31'b0, |(m_ev & m_mask)});
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
        @(negedge clk); #1;
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk); #1;
        bus_valid = 0; bus_write = 0; bus_size = 2'b10;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag,
                          input logic [1:0] sz = 2'b10);
        @(negedge clk); #1;
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = sz;
        @(negedge clk); #1;
        bus_valid = 0; bus_size = 2'b10;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk); #1;
        pin_in = v;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        idle(4);
        @(negedge clk); #1; rst = 0;
        #1;
        chk(pin_oe === 32'h0, "R9 reset pin_oe", pin_oe, 32'h0);
        chk({31'b0, irq} === 32'h0, "R9 reset irq", {31'b0, irq}, 32'h0);
        rd_chk(12'h000, 32'h0, "R9 reset direction");
        rd_chk(12'h00C, 32'h0, "R9 reset event");

        // R3 / R1: pins 0..3 outputs (bits 31..28)
        bus_wr(12'h000, 32'hF000_0000);
        bus_wr(12'h008, 32'hA5A5_A5A5);
        #1;
        chk(pin_out === 32'hA000_0000, "R3 output pins driven", pin_out, 32'hA000_0000);
        rd_chk(12'h008, 32'hA000_0000, "R1 data readback");
        rd_chk(12'h000, 32'hF000_0000, "R1 direction readback");

        // R10
        bus_wr(12'h004, 32'h1234_5678);
        rd_chk(12'h004, 32'h1234_5678, "R10 open-drain readback");
        chk(pin_od === 32'h1234_5678, "R10 pin_od", pin_od, 32'h1234_5678);

        // R5 / R7 / R4: any-edge on pin 31
        bus_wr(12'h010, 32'hFFFF_FFFF);
        bus_wr(12'h014, 32'h0);
        set_pins(32'h0000_0001);
        idle(4);
        rd_chk(12'h00C, 32'h0000_0001, "R5 rising edge sets event");
        chk({31'b0, irq} === 32'h1, "R7 irq with masked event", {31'b0, irq}, 32'h1);
        rd_chk(12'h008, 32'hA000_0001, "R4 input level in data");

        // R4: change on an output pin (pin 1, bit 30) is ignored
        set_pins(32'h4000_0001);
        idle(4);
        rd_chk(12'h00C, 32'h0000_0001, "R4 output pin raises no event");
        rd_chk(12'h008, 32'hA000_0001, "R4 output pin data unchanged");

        // R6: zero write keeps, one write clears
        bus_wr(12'h00C, 32'h0);
        rd_chk(12'h00C, 32'h0000_0001, "R6 zero write keeps flag");
        bus_wr(12'h00C, 32'h0000_0001);
        rd_chk(12'h00C, 32'h0, "R6 one write clears flag");
        chk({31'b0, irq} === 32'h0, "R7 irq low after clear", {31'b0, irq}, 32'h0);

        // R5: falling-only on bits 7..0
        bus_wr(12'h014, 32'h0000_00FF);
        set_pins(32'h4000_0102);
        idle(4);
        rd_chk(12'h00C, 32'h0000_0101, "R5 falling-only selection");

        // R7: mask selects
        bus_wr(12'h010, 32'h0000_0100);
        #1; chk({31'b0, irq} === 32'h1, "R7 irq masked in", {31'b0, irq}, 32'h1);
        bus_wr(12'h010, 32'h0000_0002);
        #1; chk({31'b0, irq} === 32'h0, "R7 irq masked out", {31'b0, irq}, 32'h0);

        // R6: edge in the same cycle as clearing write wins
        set_pins(32'h4000_0002);
        idle(1);
        bus_wr(12'h00C, 32'h0000_0100);
        rd_chk(12'h00C, 32'h0000_0101, "R6 edge beats clear");
        bus_wr(12'h00C, 32'h0000_0101);
        rd_chk(12'h00C, 32'h0, "R6 clear after collision");

        // R8: undersized accesses
        bus_wr(12'h000, 32'h0, 2'b01);
        rd_chk(12'h000, 32'hF000_0000, "R8 half write ignored");
        rd_chk(12'h000, 32'h0, "R8 half read zero", 2'b01);
        rd_chk(12'h004, 32'h0, "R8 byte read zero", 2'b00);

        // R2: unmapped and unaligned
        rd_chk(12'h018, 32'h0, "R2 unmapped 0x18");
        rd_chk(12'hFFC, 32'h0, "R2 unmapped 0xFFC");
        rd_chk(12'h002, 32'h0, "R2 unaligned read");

        // Mixed random traffic checked against the model every cycle
        for (int k = 0; k < 400; k++) begin
            @(negedge clk); #1;
            if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ (32'h1 << $urandom_range(0, 31));
            bus_valid = $urandom_range(0, 1);
            bus_write = $urandom_range(0, 1);
            bus_size  = ($urandom_range(0, 7) == 0) ? 2'b01 : 2'b10;
            bus_addr  = 12'(4 * $urandom_range(0, 6));
            bus_wdata = $urandom;
        end
        @(negedge clk); #1;
        bus_valid = 0; bus_write = 0;
        idle(5);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule